// File: doc/BRIEF.md
# Stereo Sample Pair FIFO

This block buffers stereo audio samples between a processor's memory-mapped write port and a serial audio transmitter. It holds a small number of entries, four by default. Each entry is a complete left/right pair of samples up to 24 bits wide. The transmitter side sees the oldest pair at all times and removes it with a single pop request.

The processor builds each pair from bus writes, and how it does so depends on the sample-size mode. In 16-bit mode, a halfword write stages the left sample and a second halfword write supplies the right sample. A single word write can also carry both samples at once. In 24-bit mode, two successive word writes carry the left sample and then the right sample.

A pair enters the FIFO only when its right half arrives. When a completed pair meets a full FIFO, it replaces the newest stored entry, so the oldest data keeps flowing. Writes of an unsupported width or at an unsupported offset are ignored and raise a sticky error flag. The transmitter side also sees full, empty and fill-level status.

Top module: `stereo_fifo_top`

## Requirements
- R1: After reset, empty is 1, full is 0, level is 0 and err is 0.
- R2: With mode24=0, a halfword write (wr_size=1) at wr_addr=0 stages wr_data[15:0] as left and does not change level. A following halfword write at wr_addr=2 supplies wr_data[15:0] as right and commits the pair, raising level by one. Both samples are zero-extended to 24 bits.
- R3: With mode24=0, a word write (wr_size=2) at wr_addr=0 commits one pair at once, with left taken from wr_data[15:0] and right from wr_data[31:16], both zero-extended.
- R4: With mode24=1, a word write at wr_addr=0 with no left staged stages wr_data[23:0] as left. The next such word write supplies wr_data[23:0] as right and commits the pair.
- R5: The following writes are ignored: level and any staged left are left unchanged, and err is set. They are: a byte write (wr_size=0) or wr_size=3 in either mode; any write at wr_addr 1 or 3; a halfword write in 24-bit mode; a word write at wr_addr=2; a right halfword with no left staged.
- R6: err stays 1 until a cycle with err_clr=1. If an ignored write occurs in the same cycle as err_clr=1, err remains 1.
- R7: full is 1 exactly when level equals the depth (4).
- R8: A pair committed while full, with no pop in the same cycle, replaces the newest entry. Level stays at the depth, and the older entries come out unchanged and in order.
- R9: When not empty, rd_left/rd_right show the oldest pair, and pop removes it, so pairs leave in commit order. A pop while empty changes nothing.
- R10: A commit and a pop in the same cycle while full removes the oldest pair and appends the new pair at the tail, and level stays at the depth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode24 | input | 1 | Sample size: 0 = 16-bit, 1 = 24-bit |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 2 | Byte offset of the write in the window |
| wr_size | input | 2 | Access width: 0 byte, 1 halfword, 2 word |
| wr_data | input | 32 | Write data |
| err_clr | input | 1 | Clears the sticky error flag |
| rd_pop | input | 1 | Remove the oldest pair |
| rd_left | output | 24 | Left sample of the oldest pair |
| rd_right | output | 24 | Right sample of the oldest pair |
| empty | output | 1 | No pair stored |
| full | output | 1 | All entries occupied |
| level | output | 3 | Number of stored pairs |
| err | output | 1 | Sticky invalid-write flag |

## Verification
The bench builds the block with its defaults: a depth of four, 24-bit samples and a 32-bit bus. With only four entries, every fill level, both pointer wraps and the overwrite-when-full path are reached within a few dozen writes. The small two-bit offset and two-bit size fields allow a sweep over every size, offset and mode combination, which covers each rejected access. Expected pairs are produced arithmetically from a loop index and tracked in a queue model.

// File: rtl/stereo_fifo_pkg.sv
package stereo_fifo_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum logic [1:0] {
    ACT_NONE  = 2'd0,
    ACT_LEFT  = 2'd1,
    ACT_RIGHT = 2'd2,
    ACT_BOTH  = 2'd3
  } wr_action_e;
endpackage

// File: rtl/stereo_fifo_rst_sync.sv
module stereo_fifo_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/stereo_fifo_wrfmt.sv
module stereo_fifo_wrfmt
  import stereo_fifo_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int BUS_W    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mode24,
  input  logic                  wr_en,
  input  logic [1:0]            wr_addr,
  input  logic [1:0]            wr_size,
  input  logic [BUS_W-1:0]      wr_data,
  input  logic                  err_clr,
  output logic                  commit,
  output logic [2*SAMPLE_W-1:0] commit_pair,
  output logic                  err
);
  localparam int HALF_W = BUS_W / 2;

  wr_action_e          act;
  logic                bad;
  logic                staged_q, staged_d;
  logic [SAMPLE_W-1:0] left_q, left_d;
  logic                left_en;
  logic                err_q, err_d;
  logic [SAMPLE_W-1:0] lo_half, hi_half, lo_wide;

  always_comb begin
    lo_half = SAMPLE_W'(wr_data[HALF_W-1:0]);
    hi_half = SAMPLE_W'(wr_data[BUS_W-1:HALF_W]);
    lo_wide = wr_data[SAMPLE_W-1:0];
  end

  // access classification
  always_comb begin
    act = ACT_NONE;
    bad = 1'b0;
    if (wr_en) begin
      if (mode24) begin
        if (wr_size == SZ_WORD && wr_addr == 2'd0)
          act = staged_q ? ACT_RIGHT : ACT_LEFT;
        else
          bad = 1'b1;
      end else begin
        if (wr_size == SZ_HALF && wr_addr == 2'd0)
          act = ACT_LEFT;
        else if (wr_size == SZ_HALF && wr_addr == 2'd2 && staged_q)
          act = ACT_RIGHT;
        else if (wr_size == SZ_WORD && wr_addr == 2'd0)
          act = ACT_BOTH;
        else
          bad = 1'b1;
      end
    end
  end

  // next state
  always_comb begin
    staged_d    = staged_q;
    left_en     = 1'b0;
    left_d      = left_q;
    commit      = 1'b0;
    commit_pair = '0;
    case (act)
      ACT_LEFT: begin
        staged_d = 1'b1;
        left_en  = 1'b1;
        left_d   = mode24 ? lo_wide : lo_half;
      end
      ACT_RIGHT: begin
        staged_d    = 1'b0;
        commit      = 1'b1;
        commit_pair = {left_q, (mode24 ? lo_wide : lo_half)};
      end
      ACT_BOTH: begin
        staged_d    = 1'b0;
        commit      = 1'b1;
        commit_pair = {lo_half, hi_half};
      end
      default: ;
    endcase
    err_d = bad | (err_q & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      staged_q <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      staged_q <= staged_d;
      err_q    <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       left_q <= '0;
    else if (left_en) left_q <= left_d;
  end

  assign err = err_q;

  // R5: a rejected access leaves the error flag set on the next cycle
  p_bad_sets_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> err_q);

  // R5: a rejected access keeps any staged left sample
  p_bad_keeps_stage_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> ($stable(staged_q) && $stable(left_q)));

  // R6: with no new fault, a clear request drops the flag
  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !bad) |=> !err_q);

  // R4: a 24-bit commit always follows a staged left sample
  p_pair_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode24 && commit) |-> staged_q);
endmodule

// File: rtl/stereo_fifo_store.sv
module stereo_fifo_store #(
  parameter int DEPTH    = 4,
  parameter int SAMPLE_W = 24,
  localparam int PW      = $clog2(DEPTH),
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int EW      = 2 * SAMPLE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          commit,
  input  logic [EW-1:0] commit_pair,
  input  logic          rd_pop,
  output logic [EW-1:0] head_pair,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [EW-1:0]    ent [DEPTH];
  logic [DEPTH-1:0] ent_we;
  logic [PW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d, wr_idx, newest;
  logic [CW-1:0]    count_q, count_d;
  logic             pop_ok, push, ovw;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    pop_ok   = rd_pop && (count_q != '0);
    push     = commit && ((count_q != CMAX) || pop_ok);
    ovw      = commit && (count_q == CMAX) && !pop_ok;
    newest   = (wr_ptr_q == '0) ? LAST : wr_ptr_q - 1'b1;
    wr_idx   = ovw ? newest : wr_ptr_q;
    wr_ptr_d = push ? step(wr_ptr_q) : wr_ptr_q;
    rd_ptr_d = pop_ok ? step(rd_ptr_q) : rd_ptr_q;
    count_d  = count_q;
    if (push && !pop_ok)      count_d = count_q + 1'b1;
    else if (!push && pop_ok) count_d = count_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign ent_we[g] = (push || ovw) && (wr_idx == PW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         ent[g] <= '0;
      else if (ent_we[g]) ent[g] <= commit_pair;
    end
  end

  assign head_pair = ent[rd_ptr_q];
  assign count     = count_q;
  assign full      = (count_q == CMAX);
  assign empty     = (count_q == '0);

  // R7: occupancy never exceeds depth
  p_level_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CMAX);

  // R8: overwrite keeps level and write pointer
  p_overwrite_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && full && !rd_pop) |=> (full && $stable(wr_ptr_q) && $stable(rd_ptr_q)));

  // R9: a pop on an empty store changes nothing
  p_pop_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pop && empty && !commit) |=> (empty && $stable(rd_ptr_q)));

  // R10: simultaneous commit and pop when full keeps the store full
  p_swap_full_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (commit && rd_pop && full) |=> full);
endmodule

// File: rtl/stereo_fifo_top.sv
module stereo_fifo_top #(
  parameter int DEPTH    = 4,
  parameter int SAMPLE_W = 24,
  parameter int BUS_W    = 32,
  localparam int CW      = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode24,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [1:0]          wr_size,
  input  logic [BUS_W-1:0]    wr_data,
  input  logic                err_clr,
  input  logic                rd_pop,
  output logic [SAMPLE_W-1:0] rd_left,
  output logic [SAMPLE_W-1:0] rd_right,
  output logic                empty,
  output logic                full,
  output logic [CW-1:0]       level,
  output logic                err
);
  logic                  rst_sync_n;
  logic                  commit;
  logic [2*SAMPLE_W-1:0] commit_pair, head_pair;

  stereo_fifo_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  stereo_fifo_wrfmt #(.SAMPLE_W(SAMPLE_W), .BUS_W(BUS_W)) u_wrfmt (
    .clk(clk), .rst_n(rst_sync_n), .mode24(mode24), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .err_clr(err_clr), .commit(commit), .commit_pair(commit_pair), .err(err)
  );

  stereo_fifo_store #(.DEPTH(DEPTH), .SAMPLE_W(SAMPLE_W)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .commit(commit), .commit_pair(commit_pair),
    .rd_pop(rd_pop), .head_pair(head_pair), .count(level),
    .full(full), .empty(empty)
  );

  assign rd_left  = head_pair[2*SAMPLE_W-1:SAMPLE_W];
  assign rd_right = head_pair[SAMPLE_W-1:0];
endmodule

// File: tb/stereo_fifo_top_tb.sv
module stereo_fifo_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode24 = 1'b0, wr_en = 1'b0, err_clr = 1'b0, rd_pop = 1'b0;
  logic [1:0]  wr_addr = '0, wr_size = '0;
  logic [31:0] wr_data = '0;
  logic [23:0] rd_left, rd_right;
  logic        empty, full, err;
  logic [2:0]  level;

  int checks = 0, failures = 0;
  logic [47:0] q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_fifo_top u_dut (
    .clk(clk), .rst_n(rst_n), .mode24(mode24), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_size(wr_size), .wr_data(wr_data),
    .err_clr(err_clr), .rd_pop(rd_pop), .rd_left(rd_left),
    .rd_right(rd_right), .empty(empty), .full(full), .level(level), .err(err)
  );

  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one bus cycle; outputs sampled at the following falling edge
  task automatic cyc(input logic en, input logic [1:0] sz, input logic [1:0] ad,
                     input logic [31:0] d, input logic pop, input logic clr);
    @(negedge clk);
    wr_en = en; wr_size = sz; wr_addr = ad; wr_data = d; rd_pop = pop; err_clr = clr;
    @(negedge clk);
    wr_en = 0; rd_pop = 0; err_clr = 0;
  endtask

  task automatic model_commit(input logic [47:0] p, input logic popped);
    if (popped && q.size() > 0) void'(q.pop_front());
    if (q.size() == DEPTH) q[DEPTH-1] = p;
    else q.push_back(p);
  endtask

  task automatic chk_state(input string tag);
    chk({tag, " level"}, 48'(level), 48'(q.size()));
    chk({tag, " full R7"}, 48'(full), 48'(q.size() == DEPTH));
    chk({tag, " empty"}, 48'(empty), 48'(q.size() == 0));
    if (q.size() > 0) chk({tag, " head"}, {rd_left, rd_right}, q[0]);
  endtask

  task automatic drain(input string tag);
    while (q.size() > 0) begin
      chk({tag, " head R9"}, {rd_left, rd_right}, q[0]);
      cyc(0, 0, 0, 0, 1, 0);
      void'(q.pop_front());
      chk_state({tag, " drain R9"});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] l16, r16;
    logic [23:0] l24, r24;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 empty", 48'(empty), 48'd1);
    chk("R1 full", 48'(full), 48'd0);
    chk("R1 level", 48'(level), 48'd0);
    chk("R1 err", 48'(err), 48'd0);

    // R2 halfword pairs, with R8 overwrite past full
    mode24 = 0;
    for (int i = 0; i < 6; i++) begin
      l16 = 16'h1000 + 16'(i * 16'h0111);
      r16 = 16'h8000 + 16'(i * 16'h0203);
      cyc(1, 2'd1, 2'd0, {16'hFFFF, l16}, 0, 0);
      chk("R2 level after left", 48'(level), 48'(q.size()));
      cyc(1, 2'd1, 2'd2, {16'hEEEE, r16}, 0, 0);
      model_commit({24'(l16), 24'(r16)}, 0);
      chk_state(i >= DEPTH ? "R8 overwrite" : "R2 commit");
    end
    drain("R2");
    cyc(0, 0, 0, 0, 1, 0);
    chk_state("R9 pop empty");

    // R3 single word writes carrying both samples
    for (int i = 0; i < 3; i++) begin
      l16 = 16'h0A00 + 16'(i);
      r16 = 16'hB0B0 - 16'(i * 7);
      cyc(1, 2'd2, 2'd0, {r16, l16}, 0, 0);
      model_commit({24'(l16), 24'(r16)}, 0);
      chk_state("R3 word");
    end
    drain("R3");

    // R4 24-bit pairs and R5 staging kept over a rejected write
    mode24 = 1;
    cyc(1, 2'd2, 2'd0, 32'h55_ABCDEF, 0, 0);
    chk("R4 level after left", 48'(level), 48'd0);
    cyc(1, 2'd1, 2'd0, 32'h0000_1111, 0, 0);
    chk("R5 err after half in 24-bit", 48'(err), 48'd1);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R6 cleared", 48'(err), 48'd0);
    cyc(1, 2'd2, 2'd0, 32'hAA_123456, 0, 0);
    model_commit({24'hABCDEF, 24'h123456}, 0);
    chk_state("R5 staged left kept R4");
    for (int i = 0; i < 5; i++) begin
      l24 = 24'h200000 + 24'(i * 24'h010101);
      r24 = 24'hF00000 - 24'(i * 24'h001234);
      cyc(1, 2'd2, 2'd0, {8'h77, l24}, 0, 0);
      cyc(1, 2'd2, 2'd0, {8'h66, r24}, 0, 0);
      model_commit({l24, r24}, 0);
      chk_state(q.size() == DEPTH && i == 4 ? "R8 overwrite 24" : "R4 commit");
    end
    // R10 commit with pop while full
    cyc(1, 2'd2, 2'd0, 32'h0000_0C0C, 0, 0);
    cyc(1, 2'd2, 2'd0, 32'h0000_0D0D, 1, 0);
    model_commit({24'h000C0C, 24'h000D0D}, 1);
    chk_state("R10 swap");
    drain("R10");

    // R5 sweep of rejected accesses, no left staged
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 4; s++) begin
        for (int a = 0; a < 4; a++) begin
          if (a == 0 && (s == 2 || (m == 0 && s == 1))) continue;
          mode24 = m[0];
          cyc(1, s[1:0], a[1:0], 32'h1234_5678, 0, 0);
          chk($sformatf("R5 err m%0d s%0d a%0d", m, s, a), 48'(err), 48'd1);
          chk($sformatf("R5 level m%0d s%0d a%0d", m, s, a), 48'(level), 48'd0);
          cyc(0, 0, 0, 0, 0, 1);
        end
      end
    end
    // R5 staging held in 16-bit mode across a byte write
    mode24 = 0;
    cyc(1, 2'd1, 2'd0, 32'h0000_4321, 0, 0);
    cyc(1, 2'd0, 2'd2, 32'h0000_9999, 0, 0);
    cyc(1, 2'd1, 2'd2, 32'h0000_8765, 0, 0);
    model_commit({24'h004321, 24'h008765}, 0);
    chk_state("R5 16-bit stage kept");
    // R6 fault and clear in the same cycle
    cyc(1, 2'd0, 2'd0, 0, 0, 1);
    chk("R6 set wins over clear", 48'(err), 48'd1);
    cyc(0, 0, 0, 0, 0, 0);
    chk("R6 sticky", 48'(err), 48'd1);
    cyc(0, 0, 0, 0, 0, 1);
    chk("R6 clear", 48'(err), 48'd0);
    drain("final");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule